// File: doc/BRIEF.md
# Dual-Resolution Pulse Capture Unit

This block times pulses on a digital input. A fine prescaler divides the system clock by a programmable count to make a fine tick. A loop period is 2^FINE_W fine ticks. Two capture slots are evaluated at every loop boundary. Each slot watches one of two pins. It measures either the high time (rising edge to falling edge) or the period (falling edge to the next falling edge). Its result is either high resolution, with a fine remainder in the low bits, or loop resolution only, with those bits held at zero.

Both pins pass through a two-flop synchronizer. The loop-level logic looks for edges only at loop boundaries. Each pin also has a fine timestamp structure that records where, inside the current loop, the last edge fell. Only the first high-resolution slot that references a pin may drive that structure. A loop-resolution slot never touches it. A share bit feeds pin 0 into the structures of pin 1, so a slot that names pin 1 takes a second high-resolution measurement of pin 0.

Correct results need each input phase to be longer than one loop period plus 2 clocks, and the period to be longer than two loop periods plus 2 clocks.

Top module: `dual_res_capture`

## Requirements
- R1: While reset is asserted, `cap_valid` is 0 and both result outputs are 0.
- R2: A fine tick lasts `cfg_hr_div` clocks (values of 0 and 1 both give one clock). A loop lasts 2^FINE_W fine ticks. A high-resolution slot with `slot_period`=0 (rise to fall) reports the high time in fine ticks. The result is floor(H/D) or ceil(H/D), where H is the high time in clocks and D is `cfg_hr_div`.
- R3: A high-resolution slot with `slot_period`=1 (fall to fall) reports the period in fine ticks. The result is floor(P/D) or ceil(P/D), where P is the period in clocks.
- R4: A loop-resolution slot (`slot_hr`=0) reports a value whose low FINE_W bits are zero. Its loop count, which is the value shifted right by FINE_W, is floor or ceil of the duration divided by D*2^FINE_W.
- R5: The fine structure of a pin belongs to the lowest-numbered enabled high-resolution slot that names that pin. A second high-resolution slot on the same pin reports at loop resolution, with its low FINE_W bits zero. A loop-resolution slot 0 does not take ownership, so a high-resolution slot 1 on the same pin still meets R2.
- R6: Enabling a loop-resolution slot on the same pin does not widen the spread of a high-resolution slot. Its maximum minus its minimum over a stable input stays at most 1.
- R7: With `cfg_share`=1, pin 0 feeds the edge logic and fine structure of pin 1, and the level on pin 1 is ignored. A slot with `slot_pin`=1 then measures pin 0 as in R3. With `cfg_share`=0 and pin 1 held constant, that slot reports nothing.
- R8: `cap_valid[s]` is high for one clock per completed measurement. The matching result output changes only in that clock and holds its value otherwise.
- R9: A slot whose `slot_en` bit is 0 never asserts its `cap_valid` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_hr_div | input | DIV_W | Clocks per fine tick |
| cfg_share | input | 1 | Route pin 0 into the structures of pin 1 |
| pin_in | input | 2 | Asynchronous input pins |
| slot_en | input | 2 | Enable per slot |
| slot_pin | input | 2 | Pin selected by each slot (bit s for slot s) |
| slot_period | input | 2 | 0: high time, 1: fall-to-fall period |
| slot_hr | input | 2 | 1: high resolution, 0: loop resolution |
| cap_valid | output | 2 | One-clock strobe per finished measurement |
| cap0_value | output | CNT_W+FINE_W | Slot 0 result: loops shifted left by FINE_W, adjusted by the fine remainders |
| cap1_value | output | CNT_W+FINE_W | Slot 1 result, same format |

## Verification
The bench drives square waves with seeded random phases and prescalers, and checks each result against floor and ceil bounds computed from the drive timing. It probes the slot pairings where ownership matters:
- A loop-resolution slot that is allowed to move the fine structure would push the high-resolution slot outside its one-tick band, or leak non-zero low bits into its own result.
- A second high-resolution slot on the same pin that is wrongly granted fine data would show non-zero low bits.
- For the share path, a design that ignored `cfg_share` would either keep reporting pin 1 or miss pin 0 entirely.

// File: rtl/dual_res_capture.sv
module dual_res_capture #(
  parameter int FINE_W = 2,
  parameter int CNT_W  = 14,
  parameter int DIV_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DIV_W-1:0]        cfg_hr_div,
  input  logic                    cfg_share,
  input  logic [1:0]              pin_in,
  input  logic [1:0]              slot_en,
  input  logic [1:0]              slot_pin,
  input  logic [1:0]              slot_period,
  input  logic [1:0]              slot_hr,
  output logic [1:0]              cap_valid,
  output logic [CNT_W+FINE_W-1:0] cap0_value,
  output logic [CNT_W+FINE_W-1:0] cap1_value
);
  localparam int RES_W = CNT_W + FINE_W;

  logic [1:0] sync_a, sync_b, lvl;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
    end else begin
      sync_a <= pin_in;
      sync_b <= sync_a;
    end

  assign lvl = {cfg_share ? sync_b[0] : sync_b[1], sync_b[0]};

  logic [DIV_W-1:0]  hr_cnt;
  logic [DIV_W:0]    hr_nxt;
  logic [FINE_W-1:0] phase;
  logic              tick, bnd;

  assign hr_nxt = {1'b0, hr_cnt} + (DIV_W+1)'(1);
  assign tick   = hr_nxt >= {1'b0, cfg_hr_div};
  assign bnd    = tick & (&phase);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hr_cnt <= '0;
      phase  <= '0;
    end else begin
      hr_cnt <= tick ? '0 : hr_nxt[DIV_W-1:0];
      if (tick) phase <= phase + FINE_W'(1);
    end

  logic       hr0_on, hr1_on;
  logic [1:0] slot_fine, fine_en;

  assign hr0_on    = slot_en[0] & slot_hr[0];
  assign hr1_on    = slot_en[1] & slot_hr[1];
  assign slot_fine = {hr1_on & ~(hr0_on & (slot_pin[0] == slot_pin[1])), hr0_on};

  logic [1:0]        f_edge, rise, fall;
  logic [FINE_W-1:0] rem_eff [2];

  for (genvar j = 0; j < 2; j++) begin : g_pin
    logic              f_lvl, l_lvl;
    logic [FINE_W-1:0] f_rem;

    assign fine_en[j] = (slot_fine[0] && slot_pin[0] == 1'(j)) ||
                        (slot_fine[1] && slot_pin[1] == 1'(j));
    assign f_edge[j]  = tick & fine_en[j] & (lvl[j] ^ f_lvl);
    assign rem_eff[j] = f_edge[j] ? ~phase : f_rem;
    assign rise[j]    = bnd &  lvl[j] & ~l_lvl;
    assign fall[j]    = bnd & ~lvl[j] &  l_lvl;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        f_lvl <= 1'b0;
        f_rem <= '0;
        l_lvl <= 1'b0;
      end else begin
        if (tick && fine_en[j]) f_lvl <= lvl[j];
        if (f_edge[j])          f_rem <= ~phase;
        if (bnd)                l_lvl <= lvl[j];
      end
  end

  logic [RES_W-1:0] res [2];

  for (genvar s = 0; s < 2; s++) begin : g_slot
    logic              run, vld, st, sp;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic [FINE_W-1:0] rs, rm;
    logic [RES_W-1:0]  val, meas;

    assign sp    = fall[slot_pin[s]];
    assign st    = slot_period[s] ? sp : rise[slot_pin[s]];
    assign rm    = slot_fine[s] ? rem_eff[slot_pin[s]] : '0;
    assign cnt_n = (&cnt) ? cnt : cnt + CNT_W'(1);
    assign meas  = {cnt_n, {FINE_W{1'b0}}} + RES_W'(rs) - RES_W'(rm);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        run <= 1'b0;
        vld <= 1'b0;
        cnt <= '0;
        rs  <= '0;
        val <= '0;
      end else begin
        vld <= 1'b0;
        if (!slot_en[s]) run <= 1'b0;
        else if (bnd) begin
          if (run && sp) begin
            val <= meas;
            vld <= 1'b1;
          end
          if (st) begin
            run <= 1'b1;
            cnt <= '0;
            rs  <= rm;
          end else if (sp) run <= 1'b0;
          else if (run)    cnt <= cnt_n;
        end
      end

    assign cap_valid[s] = vld;
    assign res[s]       = val;
  end

  assign cap0_value = res[0];
  assign cap1_value = res[1];
endmodule

module dual_res_capture_chk #(
  parameter int FINE_W = 2,
  parameter int CNT_W  = 14
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [1:0]              slot_en,
  input logic [1:0]              slot_hr,
  input logic [1:0]              cap_valid,
  input logic [CNT_W+FINE_W-1:0] cap0_value,
  input logic [CNT_W+FINE_W-1:0] cap1_value
);
  always @(posedge clk)
    if (!rst_n) begin
      a_reset_quiet_r1: assert (cap_valid == 2'b00 && cap0_value == '0 && cap1_value == '0);
    end

  p_lr_zero_fine0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid[0] && !slot_hr[0] |-> cap0_value[FINE_W-1:0] == '0);
  p_lr_zero_fine1_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid[1] && !slot_hr[1] |-> cap1_value[FINE_W-1:0] == '0);
  p_one_clk0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid[0] |=> !cap_valid[0]);
  p_one_clk1_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid[1] |=> !cap_valid[1]);
  p_hold0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_valid[0] |-> $stable(cap0_value));
  p_hold1_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_valid[1] |-> $stable(cap1_value));
  p_off0_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_en[0] && !$past(slot_en[0]) |-> !cap_valid[0]);
  p_off1_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_en[1] && !$past(slot_en[1]) |-> !cap_valid[1]);
endmodule

bind dual_res_capture dual_res_capture_chk #(.FINE_W(FINE_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_dual_res_capture.sv
module sim_dual_res_capture;
  localparam int FW = 2, CW = 14, DW = 8, LL = 1 << FW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0, share = 1'b0, w0 = 1'b0, w1 = 1'b0;
  logic [DW-1:0] div = 8'd5;
  logic [1:0]    en = '0, spin = '0, sper = '0, shr = '0, vld;
  logic [CW+FW-1:0] v0, v1;

  dual_res_capture #(.FINE_W(FW), .CNT_W(CW), .DIV_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_hr_div(div), .cfg_share(share),
    .pin_in({w1, w0}), .slot_en(en), .slot_pin(spin), .slot_period(sper),
    .slot_hr(shr), .cap_valid(vld), .cap0_value(v0), .cap1_value(v1));

  int tests = 0, fails = 0, cyc = 0, wh = 100, wl = 100;
  bit clr = 1'b0, done = 1'b0;
  int n[2], mn[2], mx[2], fbad[2], skip[2], pbad = 0, hbad = 0;
  logic [1:0] pv;
  logic [CW+FW-1:0] last[2];

  always begin
    w0 = 1'b1;
    repeat (wh) @(negedge clk);
    w0 = 1'b0;
    repeat (wl) @(negedge clk);
  end

  always @(negedge clk) begin
    cyc++;
    if (clr || !rst_n) begin
      for (int s = 0; s < 2; s++) begin
        if (clr) begin
          n[s] = 0; mn[s] = 1 << 30; mx[s] = -1; fbad[s] = 0; skip[s] = 2;
        end
        last[s] = s ? v1 : v0;
      end
      pv = '0;
    end else begin
      for (int s = 0; s < 2; s++) begin
        logic [CW+FW-1:0] val;
        val = s ? v1 : v0;
        if (vld[s] && pv[s]) pbad++;
        if (!vld[s] && val != last[s]) hbad++;
        last[s] = val;
        if (vld[s]) begin
          if (skip[s] > 0) skip[s]--;
          else begin
            n[s]++;
            if (int'(val) < mn[s]) mn[s] = int'(val);
            if (int'(val) > mx[s]) mx[s] = int'(val);
            if (val[FW-1:0] != '0) fbad[s]++;
          end
        end
      end
      pv = vld;
    end
    if (cyc > 190000 && !done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: cycles %0d expected below 190000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_case(input int d, input int h, input int l, input logic [1:0] e,
                          input logic [1:0] p, input logic [1:0] per, input logic [1:0] hr,
                          input logic sh, input logic lvl1);
    @(posedge clk); #2;
    rst_n = 1'b0;
    div = DW'(d); wh = h; wl = l; en = e; spin = p; sper = per; shr = hr;
    share = sh; w1 = lvl1; clr = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    clr = 1'b0; rst_n = 1'b1;
    repeat (10 * (h + l) + 64 * d + 100) @(posedge clk);
    #2;
  endtask

  task automatic hr_check(input int s, input int dur, input int d, input string tag);
    chk(n[s] >= 3, {tag, " count"}, n[s], 3);
    chk(mn[s] >= dur / d, {tag, " min"}, mn[s], dur / d);
    chk(mx[s] <= (dur + d - 1) / d, {tag, " max"}, mx[s], (dur + d - 1) / d);
    chk(mx[s] - mn[s] <= 1, {tag, " spread"}, mx[s] - mn[s], 1);
  endtask

  task automatic lr_check(input int s, input int dur, input int d, input string tag);
    int q;
    q = d * LL;
    chk(n[s] >= 3, {tag, " count"}, n[s], 3);
    chk(fbad[s] == 0, {tag, " fine bits zero"}, fbad[s], 0);
    chk(mn[s] >= (dur / q) * LL, {tag, " min"}, mn[s], (dur / q) * LL);
    chk(mx[s] <= ((dur + q - 1) / q) * LL, {tag, " max"}, mx[s], ((dur + q - 1) / q) * LL);
  endtask

  initial begin
    int sp_alone;
    void'($urandom(32'd1234));
    repeat (4) @(posedge clk);
    #2;
    chk(vld == 2'b00, "R1 valid in reset", int'(vld), 0);
    chk(v0 == '0 && v1 == '0, "R1 results in reset", int'(v0) + int'(v1), 0);

    // R2: lone high-res high-time slot
    run_case(5, 100, 100, 2'b01, 2'b00, 2'b00, 2'b01, 1'b0, 1'b0);
    hr_check(0, 100, 5, "R2 lone slot");
    chk(n[1] == 0, "R9 disabled slot", n[1], 0);
    sp_alone = mx[0] - mn[0];

    // R6 / R4: add a loop-res period slot on the same pin
    run_case(5, 100, 100, 2'b11, 2'b00, 2'b10, 2'b01, 1'b0, 1'b0);
    hr_check(0, 100, 5, "R2 with neighbour");
    chk(mx[0] - mn[0] <= ((sp_alone > 1) ? sp_alone : 1), "R6 spread not widened",
        mx[0] - mn[0], sp_alone);
    lr_check(1, 200, 5, "R4 loop-res period");

    run_case(3, 50, 77, 2'b11, 2'b00, 2'b10, 2'b01, 1'b0, 1'b0);
    hr_check(0, 50, 3, "R6 uneven wave");
    lr_check(1, 127, 3, "R4 uneven wave");

    // R3: high-res period
    run_case(4, 37, 61, 2'b01, 2'b00, 2'b01, 2'b01, 1'b0, 1'b0);
    hr_check(0, 98, 4, "R3 hr period");

    // R5: two high-res slots on one pin, second is demoted
    run_case(3, 40, 55, 2'b11, 2'b00, 2'b10, 2'b11, 1'b0, 1'b0);
    hr_check(0, 40, 3, "R5 owner");
    lr_check(1, 95, 3, "R5 non-owner");

    // R5: loop-res slot 0 leaves ownership to slot 1
    run_case(2, 33, 29, 2'b11, 2'b00, 2'b01, 2'b10, 1'b0, 1'b0);
    lr_check(0, 62, 2, "R5 lr slot0");
    hr_check(1, 33, 2, "R5 hr slot1 owns");

    // R7: share routes pin 0 into pin 1 structures
    run_case(5, 90, 70, 2'b11, 2'b10, 2'b10, 2'b11, 1'b1, 1'b1);
    hr_check(0, 90, 5, "R7 pin0 slot");
    hr_check(1, 160, 5, "R7 shared slot");
    run_case(5, 90, 70, 2'b11, 2'b10, 2'b10, 2'b11, 1'b0, 1'b1);
    chk(n[1] == 0, "R7 no share, idle pin1", n[1], 0);
    hr_check(0, 90, 5, "R7 pin0 unaffected");

    for (int k = 0; k < 10; k++) begin
      int d, h, l, mode;
      d = 1 + int'($urandom % 6);
      h = LL * d + 3 + int'($urandom % (LL * d * 6));
      l = LL * d + 3 + int'($urandom % (LL * d * 6));
      mode = int'($urandom % 3);
      run_case(d, h, l, (mode == 0) ? 2'b01 : 2'b11, 2'b00, 2'b10,
               (mode == 2) ? 2'b11 : 2'b01, 1'b0, 1'b0);
      hr_check(0, h, d, "R2/R6 random");
      if (mode == 0) chk(n[1] == 0, "R9 random disabled", n[1], 0);
      else if (mode == 1) lr_check(1, h + l, d, "R4 random");
      else lr_check(1, h + l, d, "R5 random non-owner");
    end

    chk(pbad == 0, "R8 one-clock strobe", pbad, 0);
    chk(hbad == 0, "R8 result held", hbad, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule